// File: doc/BRIEF.md
# Data Address Watchpoint Debug Unit

This unit watches the data addresses of load and store accesses and compares them against a set of programmed watch addresses. A hit records itself in a sticky status register, with one read bit and one write bit per comparator. What follows a hit depends on the debug mode.

- In internal debug mode with debug interrupts enabled, the unit requests a debug interrupt.
- With debug interrupts masked, it flags the event as imprecise. The interrupt then fires once the enable bit is raised, unless software has already cleared the status bit.
- In trace mode it only pulses a trace output.

Several sub-accesses can arrive in the same cycle, one per lane, for example the halves of a misaligned access or the words of a multi-word transfer. Each lane is compared on its own. Cache block zero and cache block invalidate operations are classed as stores. Comparators 0 and 1 can be paired into an address range outside trace mode. Software clears status bits with a write-one-to-clear mask.

Top module: `daw_unit`

## Requirements
- R1: A lane hits comparator k when the address bits at and above GRAN_LSB equal those of watch address k. Status bit layout:
  - bit 2k records a read hit and is set only when read enable k is 1;
  - bit 2k+1 records a write hit and is set only when write enable k is 1;
  - bit 2*NUM_CMP is the imprecise flag.
- R2: In internal mode (not trace) with the debug-enable input at 1, a hit sets its status bit on the next clock edge. irq_o is high whenever the debug-enable input is 1, the unit is in internal mode and not in trace mode, and at least one compare status bit whose enable is set is 1.
- R3: In internal mode, with external-halt mode at 0, trace mode at 0 and debug-enable at 0, a hit sets its status bit and the imprecise bit, and irq_o stays low.
- R4: A pending compare bit raises irq_o in the same cycle that debug-enable becomes 1. If the bit was cleared first, irq_o stays low.
- R5: In trace mode, a hit sets its status bit and drives trace_evt_o high for exactly the one cycle after the access. It does not set the imprecise bit and never raises irq_o.
- R6: With pair_i at 1 and trace mode at 0, comparator 0 matches the granule range [watch0, watch1) using comparator 0's enables, and comparator 1 never hits. In trace mode, pair_i has no effect and both comparators match exactly.
- R7: Each of the NUM_SUB lanes is compared independently, and hits from different lanes in the same cycle all set their bits.
- R8: Lane class 2'b00 takes its direction from acc_write_i. Classes 2'b01 (block zero) and 2'b10 (block invalidate) are writes whatever acc_write_i says. Class 2'b11 is a read.
- R9: While clr_valid_i is 1, every status bit whose clr_mask_i bit is 1 is cleared on the clock edge. A hit on the same bit in the same cycle wins, and the bit stays set.
- R10: After reset, status_o, irq_o and trace_evt_o are 0.
- R11: With internal, external-halt and trace modes all 0, hits change no status. In external-halt mode without trace, a hit sets its compare bit but not the imprecise bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | NUM_SUB | Lane carries an access this cycle |
| acc_write_i | input | NUM_SUB | Lane direction for class 00 (1 = store) |
| acc_cls_i | input | 2*NUM_SUB | Lane class: 00 plain, 01 block zero, 10 block invalidate, 11 other cache op |
| acc_addr_i | input | NUM_SUB*ADDR_W | Lane data addresses |
| cmp_addr_i | input | NUM_CMP*ADDR_W | Watch addresses |
| cmp_rd_en_i | input | NUM_CMP | Read-match enable per comparator |
| cmp_wr_en_i | input | NUM_CMP | Write-match enable per comparator |
| pair_i | input | 1 | Pair comparators 0 and 1 as a range |
| int_mode_i | input | 1 | Internal debug mode |
| ext_mode_i | input | 1 | External or halt-wait debug mode |
| trace_mode_i | input | 1 | Trace mode |
| dbg_en_i | input | 1 | Debug interrupt enable |
| clr_valid_i | input | 1 | Status clear strobe |
| clr_mask_i | input | 2*NUM_CMP+1 | Write-one-to-clear mask |
| status_o | output | 2*NUM_CMP+1 | Status register |
| irq_o | output | 1 | Debug interrupt request |
| trace_evt_o | output | 1 | Trace event pulse |

## Verification
The bench builds the unit with ADDR_W=16, NUM_CMP=2, NUM_SUB=2 and GRAN_LSB=2. The narrow address space and random addresses drawn within a few granules of the watch points make exact hits, near misses and range edges frequent. Two lanes allow same-cycle hits on both comparators. Two comparators are the minimum needed to exercise pairing, and pairing is tried both inside and outside trace mode.

// File: rtl/daw_pkg.sv
package daw_pkg;
  typedef enum logic [1:0] {
    CLS_PLAIN = 2'b00,
    CLS_ZERO  = 2'b01,
    CLS_INVAL = 2'b10,
    CLS_OTHER = 2'b11
  } acc_cls_e;

  function automatic logic cls_is_store(acc_cls_e cls, logic wr);
    case (cls)
      CLS_PLAIN: return wr;
      CLS_ZERO,
      CLS_INVAL: return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/daw_kind_dec.sv
module daw_kind_dec
  import daw_pkg::*;
#(
  parameter int NUM_SUB = 2
) (
  input  logic [NUM_SUB-1:0]   valid_i,
  input  logic [NUM_SUB-1:0]   write_i,
  input  logic [2*NUM_SUB-1:0] cls_i,
  output logic [NUM_SUB-1:0]   rd_v_o,
  output logic [NUM_SUB-1:0]   wr_v_o
);
  for (genvar s = 0; s < NUM_SUB; s++) begin : g_lane
    logic st;
    assign st        = cls_is_store(acc_cls_e'(cls_i[2*s +: 2]), write_i[s]);
    assign wr_v_o[s] = valid_i[s] & st;
    assign rd_v_o[s] = valid_i[s] & ~st;
  end
endmodule

// File: rtl/daw_cmp_match.sv
module daw_cmp_match #(
  parameter int ADDR_W   = 32,
  parameter int NUM_CMP  = 2,
  parameter int NUM_SUB  = 2,
  parameter int GRAN_LSB = 2,
  localparam int HIT_W   = 2*NUM_CMP
) (
  input  logic [NUM_SUB*ADDR_W-1:0] acc_addr_i,
  input  logic [NUM_SUB-1:0]        rd_v_i,
  input  logic [NUM_SUB-1:0]        wr_v_i,
  input  logic [NUM_CMP*ADDR_W-1:0] cmp_addr_i,
  input  logic [NUM_CMP-1:0]        cmp_rd_en_i,
  input  logic [NUM_CMP-1:0]        cmp_wr_en_i,
  input  logic                      pair_i,
  input  logic                      trace_mode_i,
  output logic [HIT_W-1:0]          hit_o
);
  localparam int SEL_W = NUM_SUB*NUM_CMP;

  logic [ADDR_W-1:0] tag_a [NUM_SUB];
  logic [ADDR_W-1:0] tag_w [NUM_CMP];
  logic [SEL_W-1:0]  sel;
  logic [NUM_SUB-1:0] in_rng;
  logic pair_act;

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_ta
    assign tag_a[s] = acc_addr_i[s*ADDR_W +: ADDR_W] >> GRAN_LSB;
  end
  for (genvar c = 0; c < NUM_CMP; c++) begin : g_tw
    assign tag_w[c] = cmp_addr_i[c*ADDR_W +: ADDR_W] >> GRAN_LSB;
  end

  // range pairing exists only with two or more comparators; ignored in trace mode
  if (NUM_CMP >= 2) begin : g_pair
    assign pair_act = pair_i & ~trace_mode_i;
    for (genvar s = 0; s < NUM_SUB; s++) begin : g_rng
      assign in_rng[s] = (tag_a[s] >= tag_w[0]) && (tag_a[s] < tag_w[1]);
    end
  end else begin : g_nopair
    assign pair_act = 1'b0;
    assign in_rng   = '0;
  end

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_s
    for (genvar c = 0; c < NUM_CMP; c++) begin : g_c
      logic eq;
      assign eq = (tag_a[s] == tag_w[c]);
      if (c == 0) begin : g_c0
        assign sel[s*NUM_CMP+c] = pair_act ? in_rng[s] : eq;
      end else if (c == 1) begin : g_c1
        assign sel[s*NUM_CMP+c] = ~pair_act & eq;
      end else begin : g_cn
        assign sel[s*NUM_CMP+c] = eq;
      end
    end
  end

  always_comb begin
    hit_o = '0;
    for (int c = 0; c < NUM_CMP; c++) begin
      for (int s = 0; s < NUM_SUB; s++) begin
        hit_o[2*c]   = hit_o[2*c]   | (rd_v_i[s] & sel[s*NUM_CMP+c] & cmp_rd_en_i[c]);
        hit_o[2*c+1] = hit_o[2*c+1] | (wr_v_i[s] & sel[s*NUM_CMP+c] & cmp_wr_en_i[c]);
      end
    end
  end
endmodule

// File: rtl/daw_status.sv
module daw_status #(
  parameter int NUM_CMP = 2,
  localparam int HIT_W  = 2*NUM_CMP,
  localparam int STAT_W = HIT_W+1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HIT_W-1:0]  hit_i,
  input  logic [HIT_W-1:0]  en_mask_i,
  input  logic              int_mode_i,
  input  logic              ext_mode_i,
  input  logic              trace_mode_i,
  input  logic              dbg_en_i,
  input  logic              clr_valid_i,
  input  logic [STAT_W-1:0] clr_mask_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o,
  output logic              trace_evt_o
);
  localparam int IMP = HIT_W;

  logic [STAT_W-1:0] stat_q, stat_d, set_vec, clr_vec;
  logic any_hit, record, trace_q;

  always_comb begin
    any_hit      = |hit_i;
    record       = trace_mode_i | int_mode_i | ext_mode_i;
    set_vec      = '0;
    set_vec[HIT_W-1:0] = record ? hit_i : '0;
    // masked internal-only event: deferred and flagged imprecise
    set_vec[IMP] = any_hit & ~trace_mode_i & int_mode_i & ~ext_mode_i & ~dbg_en_i;
    clr_vec      = clr_valid_i ? clr_mask_i : '0;
    stat_d       = (stat_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      trace_q <= 1'b0;
    end else begin
      stat_q  <= stat_d;
      trace_q <= any_hit & trace_mode_i;
    end
  end

  assign status_o    = stat_q;
  assign trace_evt_o = trace_q;
  assign irq_o       = dbg_en_i & int_mode_i & ~trace_mode_i &
                       (|(stat_q[HIT_W-1:0] & en_mask_i));

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_i && record) |=> ((stat_q[HIT_W-1:0] & $past(hit_i)) == $past(hit_i)));

  p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_valid_i && ((clr_mask_i & set_vec) == '0)) |=> ((stat_q & $past(clr_mask_i)) == '0));

  p_imp_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[IMP] && !(clr_valid_i && clr_mask_i[IMP])) |=> stat_q[IMP]);

  p_trace_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trace_q |-> $past(trace_mode_i));

  p_irq_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|stat_q[HIT_W-1:0]));
endmodule

// File: rtl/daw_unit.sv
module daw_unit
  import daw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_CMP  = 2,
  parameter int NUM_SUB  = 2,
  parameter int GRAN_LSB = 2,
  localparam int HIT_W   = 2*NUM_CMP,
  localparam int STAT_W  = HIT_W+1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SUB-1:0]        acc_valid_i,
  input  logic [NUM_SUB-1:0]        acc_write_i,
  input  logic [2*NUM_SUB-1:0]      acc_cls_i,
  input  logic [NUM_SUB*ADDR_W-1:0] acc_addr_i,
  input  logic [NUM_CMP*ADDR_W-1:0] cmp_addr_i,
  input  logic [NUM_CMP-1:0]        cmp_rd_en_i,
  input  logic [NUM_CMP-1:0]        cmp_wr_en_i,
  input  logic                      pair_i,
  input  logic                      int_mode_i,
  input  logic                      ext_mode_i,
  input  logic                      trace_mode_i,
  input  logic                      dbg_en_i,
  input  logic                      clr_valid_i,
  input  logic [STAT_W-1:0]         clr_mask_i,
  output logic [STAT_W-1:0]         status_o,
  output logic                      irq_o,
  output logic                      trace_evt_o
);
  logic [NUM_SUB-1:0] rd_v, wr_v;
  logic [HIT_W-1:0]   hit, en_mask;

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_en
    assign en_mask[2*c]   = cmp_rd_en_i[c];
    assign en_mask[2*c+1] = cmp_wr_en_i[c];
  end

  daw_kind_dec #(.NUM_SUB(NUM_SUB)) u_kind (
    .valid_i (acc_valid_i),
    .write_i (acc_write_i),
    .cls_i   (acc_cls_i),
    .rd_v_o  (rd_v),
    .wr_v_o  (wr_v)
  );

  daw_cmp_match #(
    .ADDR_W(ADDR_W), .NUM_CMP(NUM_CMP), .NUM_SUB(NUM_SUB), .GRAN_LSB(GRAN_LSB)
  ) u_match (
    .acc_addr_i   (acc_addr_i),
    .rd_v_i       (rd_v),
    .wr_v_i       (wr_v),
    .cmp_addr_i   (cmp_addr_i),
    .cmp_rd_en_i  (cmp_rd_en_i),
    .cmp_wr_en_i  (cmp_wr_en_i),
    .pair_i       (pair_i),
    .trace_mode_i (trace_mode_i),
    .hit_o        (hit)
  );

  daw_status #(.NUM_CMP(NUM_CMP)) u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hit_i        (hit),
    .en_mask_i    (en_mask),
    .int_mode_i   (int_mode_i),
    .ext_mode_i   (ext_mode_i),
    .trace_mode_i (trace_mode_i),
    .dbg_en_i     (dbg_en_i),
    .clr_valid_i  (clr_valid_i),
    .clr_mask_i   (clr_mask_i),
    .status_o     (status_o),
    .irq_o        (irq_o),
    .trace_evt_o  (trace_evt_o)
  );

  p_blk_store_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i[0] && (acc_cls_i[1:0] == CLS_ZERO || acc_cls_i[1:0] == CLS_INVAL))
      |-> (wr_v[0] && !rd_v[0]));

  p_valid_kind_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rd_v | wr_v) <= $countones(acc_valid_i));

  if (NUM_CMP >= 2) begin : g_pair_chk
    p_pair_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pair_i && !trace_mode_i) |-> (hit[3:2] == 2'b00));
  end
endmodule

// File: tb/daw_unit_bench.sv
module daw_unit_bench;
  localparam int AW = 16;
  localparam int NC = 2;
  localparam int NS = 2;
  localparam int GL = 2;
  localparam int HW = 2*NC;
  localparam int SW = HW+1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NS-1:0]   a_valid, a_write;
  logic [1:0]      a_cls  [NS];
  logic [AW-1:0]   a_addr [NS];
  logic [AW-1:0]   w_addr [NC];
  logic [NC-1:0]   rd_en, wr_en;
  logic            pair, int_m, ext_m, trc_m, de, clr_v;
  logic [SW-1:0]   clr_m;

  logic [2*NS-1:0]  cls_flat;
  logic [NS*AW-1:0] addr_flat;
  logic [NC*AW-1:0] waddr_flat;
  logic [SW-1:0]    status;
  logic             irq, trc_evt;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      cls_flat[2*s +: 2]   = a_cls[s];
      addr_flat[s*AW +: AW] = a_addr[s];
    end
    for (int c = 0; c < NC; c++) waddr_flat[c*AW +: AW] = w_addr[c];
  end

  daw_unit #(.ADDR_W(AW), .NUM_CMP(NC), .NUM_SUB(NS), .GRAN_LSB(GL)) u_daw_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(a_valid), .acc_write_i(a_write), .acc_cls_i(cls_flat),
    .acc_addr_i(addr_flat), .cmp_addr_i(waddr_flat),
    .cmp_rd_en_i(rd_en), .cmp_wr_en_i(wr_en), .pair_i(pair),
    .int_mode_i(int_m), .ext_mode_i(ext_m), .trace_mode_i(trc_m),
    .dbg_en_i(de), .clr_valid_i(clr_v), .clr_mask_i(clr_m),
    .status_o(status), .irq_o(irq), .trace_evt_o(trc_evt)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [SW-1:0] exp_stat = '0;

  task automatic chk(string tag, string what, logic [SW-1:0] act, logic [SW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [HW-1:0] model_hits();
    logic [HW-1:0] h = '0;
    for (int s = 0; s < NS; s++) begin
      if (a_valid[s]) begin
        logic st, m, pr;
        logic [AW-1:0] ta;
        st = (a_cls[s] == 2'b01 || a_cls[s] == 2'b10) ? 1'b1 :
             (a_cls[s] == 2'b11) ? 1'b0 : a_write[s];
        ta = a_addr[s] >> GL;
        pr = pair && !trc_m;
        for (int c = 0; c < NC; c++) begin
          if (pr && c == 0)      m = (ta >= (w_addr[0] >> GL)) && (ta < (w_addr[1] >> GL));
          else if (pr && c == 1) m = 1'b0;
          else                   m = (ta == (w_addr[c] >> GL));
          if (m && st && wr_en[c])   h[2*c+1] = 1'b1;
          if (m && !st && rd_en[c])  h[2*c]   = 1'b1;
        end
      end
    end
    return h;
  endfunction

  function automatic logic model_irq();
    logic [HW-1:0] en;
    for (int c = 0; c < NC; c++) begin
      en[2*c] = rd_en[c];
      en[2*c+1] = wr_en[c];
    end
    return de && int_m && !trc_m && (|(exp_stat[HW-1:0] & en));
  endfunction

  // inputs are applied at the negative edge before the call
  task automatic step(string tag);
    logic [HW-1:0] h;
    logic [SW-1:0] set;
    #1 chk(tag, "irq_pre", {{(SW-1){1'b0}}, irq}, {{(SW-1){1'b0}}, model_irq()});
    h = model_hits();
    set = '0;
    if (trc_m || int_m || ext_m) set[HW-1:0] = h;
    set[HW] = (|h) && !trc_m && int_m && !ext_m && !de;
    @(posedge clk);
    #2;
    exp_stat = (exp_stat & ~(clr_v ? clr_m : '0)) | set;
    chk(tag, "status", status, exp_stat);
    chk(tag, "trace", {{(SW-1){1'b0}}, trc_evt}, {{(SW-1){1'b0}}, (|h) && trc_m});
    chk(tag, "irq", {{(SW-1){1'b0}}, irq}, {{(SW-1){1'b0}}, model_irq()});
    @(negedge clk);
  endtask

  task automatic idle();
    a_valid = '0; a_write = '0; clr_v = 1'b0; clr_m = '0;
    for (int s = 0; s < NS; s++) begin a_cls[s] = 2'b00; a_addr[s] = '0; end
  endtask

  task automatic lane(int s, logic [AW-1:0] ad, logic wr, logic [1:0] cl);
    a_valid[s] = 1'b1; a_addr[s] = ad; a_write[s] = wr; a_cls[s] = cl;
  endtask

  initial begin
    #(8*150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk-n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle();
    w_addr[0] = 16'h0100; w_addr[1] = 16'h0140;
    rd_en = '1; wr_en = '1;
    pair = 0; int_m = 0; ext_m = 0; trc_m = 0; de = 0;
    #20;
    chk("R10", "reset status", status, '0);
    chk("R10", "reset irq", {{(SW-1){1'b0}}, irq}, '0);
    chk("R10", "reset trace", {{(SW-1){1'b0}}, trc_evt}, '0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);

    // R2 precise interrupt, granule match on low bits
    int_m = 1; de = 1;
    lane(0, 16'h0103, 1'b0, 2'b00); step("R2");
    idle(); step("R2");
    clr_v = 1; clr_m = 5'b00001; step("R9");
    idle(); step("R9");
    // R1 disabled read enable ignores read hit
    rd_en = 2'b10; lane(0, 16'h0100, 1'b0, 2'b00); step("R1");
    rd_en = '1; idle();
    // R3 masked: imprecise, no irq; R4 irq when enable rises
    de = 0; lane(0, 16'h0140, 1'b1, 2'b00); step("R3");
    idle(); step("R3");
    de = 1; step("R4");
    clr_v = 1; clr_m = '1; step("R4");
    // R4 cleared before enable: no irq
    idle(); de = 0; lane(1, 16'h0100, 1'b1, 2'b00); step("R4");
    idle(); clr_v = 1; clr_m = 5'b00010; step("R4");
    idle(); de = 1; step("R4");
    // R9 hit and clear together
    lane(0, 16'h0100, 1'b0, 2'b00); clr_v = 1; clr_m = 5'b00001; step("R9");
    idle(); clr_v = 1; clr_m = '1; step("R9");
    // R5 trace with pairing set: exact compare, pulse once
    idle(); int_m = 0; trc_m = 1; pair = 1;
    lane(0, 16'h0141, 1'b1, 2'b00); step("R5");
    idle(); step("R5");
    lane(0, 16'h0120, 1'b0, 2'b00); step("R6");
    idle(); clr_v = 1; clr_m = '1; step("R5");
    // R6 range pairing outside trace
    idle(); trc_m = 0; int_m = 1;
    lane(0, 16'h0120, 1'b0, 2'b00); step("R6");
    idle(); lane(0, 16'h0140, 1'b1, 2'b00); step("R6");
    idle(); lane(0, 16'h00FC, 1'b1, 2'b00); step("R6");
    idle(); clr_v = 1; clr_m = '1; pair = 0; step("R6");
    // R8 classes
    idle(); lane(0, 16'h0100, 1'b0, 2'b01); step("R8");
    idle(); lane(0, 16'h0140, 1'b0, 2'b10); step("R8");
    idle(); lane(1, 16'h0140, 1'b1, 2'b11); step("R8");
    idle(); clr_v = 1; clr_m = '1; step("R8");
    // R7 two lanes, both comparators
    idle(); lane(0, 16'h0100, 1'b1, 2'b00); lane(1, 16'h0142, 1'b0, 2'b00); step("R7");
    idle(); clr_v = 1; clr_m = '1; step("R7");
    // R11 no mode, then external only
    idle(); int_m = 0; lane(0, 16'h0100, 1'b1, 2'b00); step("R11");
    ext_m = 1; de = 0; step("R11");
    idle(); clr_v = 1; clr_m = '1; step("R11");

    // random mix
    idle();
    for (int i = 0; i < 3000; i++) begin
      int r;
      idle();
      for (int s = 0; s < NS; s++) begin
        if ($urandom_range(0, 2) != 0)
          lane(s, w_addr[$urandom_range(0, NC-1)] + AW'($urandom_range(0, 24)) - AW'(8),
               1'($urandom), 2'($urandom));
      end
      r = $urandom_range(0, 9);
      trc_m = (r < 2);
      int_m = (r >= 2 && r < 8);
      ext_m = (r == 8) || (r == 3);
      de    = ($urandom_range(0, 2) == 0);
      pair  = ($urandom_range(0, 3) == 0);
      rd_en = 2'($urandom); wr_en = 2'($urandom);
      if ($urandom_range(0, 4) == 0) begin clr_v = 1; clr_m = 5'($urandom); end
      step("RND");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk-n_fail, n_chk);
    $finish;
  end
endmodule